// File: doc/BRIEF.md
# Two-Bank Level Interrupt Controller

This block gathers 64 level-type interrupt request lines into two 32-bit banks: a low bank for sources 0 to 31 and an extended bank for sources 32 to 63. Each source has a sticky flag bit that software acknowledges by writing a one. Each source also has an enable bit. A status view reports the flags that are both set and enabled. The OR of all status bits drives a single registered interrupt line to the processor.

Software reaches the registers over a plain 32-bit bus with byte offsets. Writes take effect on the clock edge. Reads return data in the same cycle. Software services sources in a fixed order: the whole low bank comes first, then the extended bank, and within a bank the lowest bit comes first. A priority encoder follows the same order and presents the index of the next source to serve, together with a valid bit.

Top module: `irq_bank_ctrl`

## Requirements
- R1: Source s with s below 32 maps to bit s of the low-bank registers. Source s of 32 or more maps to bit s-32 of the extended-bank registers.
- R2: The flag registers sit at offset 0x00 (low bank) and 0x04 (extended bank). A read returns the raw flag bits. Writing a one to a bit clears that flag on the write edge. Writing a zero leaves the flag unchanged.
- R3: The enable registers sit at offset 0x10 (low bank) and 0x14 (extended bank). They can be written and read back. A one unmasks the source.
- R4: The status registers sit at offset 0x18 (low bank) and 0x1C (extended bank). They are read-only. Each bit reads as its flag AND its enable.
- R5: irq_o is high exactly one cycle after any status bit is set. It falls one cycle after the last status bit clears.
- R6: pend_vld_o is high whenever any status bit is set. pend_idx_o is then the lowest set source number, and the whole low bank ranks before the extended bank. In the same cycle both outputs follow the status bits. When nothing is pending, pend_idx_o is 0.
- R7: After reset all flags, all enables and irq_o are zero. No source reaches irq_o until software sets its enable bit.
- R8: A flag sets on every clock edge at which its line is high, and it holds after the line falls. When a clear and a high line meet on the same edge, the flag stays set.
- R9: Reads of unmapped offsets, such as 0x08, return zero. Writes to unmapped offsets, and to the status offsets, change no state. rd_data_o is zero while rd_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_lines_i | input | 64 | Level interrupt request lines, one per source |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Read data, valid in the same cycle as rd_en_i |
| irq_o | output | 1 | Registered combined interrupt to the processor |
| pend_idx_o | output | 6 | Lowest pending source number |
| pend_vld_o | output | 1 | A source is pending |

## Verification
A bad flag bit shows up within one cycle in two places: the flag readback and, once the source is enabled, the status readback and pend_idx_o. It reaches irq_o one cycle after that. A bad enable bit shows only when its flag is set, so the bench pairs every enable change with a live flag. Ordering faults show as a wrong pend_idx_o after each single-bit acknowledge while several sources are pending across both banks. Lost level re-assertion shows as a flag that is clear right after an acknowledge made while the line is still high.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned CLR_OFS  = 'h00;
  localparam int unsigned EN_OFS   = 'h10;
  localparam int unsigned STAT_OFS = 'h18;
  localparam int unsigned REG_STEP = 4;
endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] line_i,
  input  logic         clr_we_i,
  input  logic         en_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] flag_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] status_o
);
  logic [W-1:0] flag_q, en_q, clr_mask;
  logic         past_vld_q;

  assign clr_mask = clr_we_i ? wdata_i : '0;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q     <= '0;
      en_q       <= '0;
      past_vld_q <= 1'b0;
    end else begin
      flag_q     <= (flag_q & ~clr_mask) | line_i;
      past_vld_q <= 1'b1;
      if (en_we_i) en_q <= wdata_i;
    end
  end

  assign flag_o   = flag_q;
  assign en_o     = en_q;
  assign status_o = flag_q & en_q;

  p_line_sets_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld_q |-> ((flag_q & $past(line_i)) == $past(line_i)));

  p_set_only_by_line_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld_q |-> ((flag_q & ~$past(flag_q) & ~$past(line_i)) == '0));

  p_hold_without_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_vld_q && !$past(clr_we_i)) |-> ((~flag_q & $past(flag_q)) == '0));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N     = 64,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             vld_o
);
  // downward scan leaves the lowest set bit
  always_comb begin
    idx_o = '0;
    vld_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IDX_W'(i);
        vld_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl #(
  parameter int unsigned N_SRC  = 64,
  parameter int unsigned BANK_W = 32,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned N_BANKS = N_SRC / BANK_W,
  localparam int unsigned IDX_W   = $clog2(N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_lines_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [BANK_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [BANK_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic [IDX_W-1:0]  pend_idx_o,
  output logic              pend_vld_o
);
  import irq_pkg::*;

  logic [BANK_W-1:0] flag_w   [N_BANKS];
  logic [BANK_W-1:0] en_w     [N_BANKS];
  logic [BANK_W-1:0] status_w [N_BANKS];
  logic [N_SRC-1:0]  status_all;
  logic              irq_q, past_vld_q;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic clr_we, en_we;
    assign clr_we = wr_en_i && (addr_i == ADDR_W'(CLR_OFS + REG_STEP * b));
    assign en_we  = wr_en_i && (addr_i == ADDR_W'(EN_OFS + REG_STEP * b));

    irq_bank #(.W(BANK_W)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .line_i   (irq_lines_i[b*BANK_W +: BANK_W]),
      .clr_we_i (clr_we),
      .en_we_i  (en_we),
      .wdata_i  (wr_data_i),
      .flag_o   (flag_w[b]),
      .en_o     (en_w[b]),
      .status_o (status_w[b])
    );
    assign status_all[b*BANK_W +: BANK_W] = status_w[b];
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) begin
      for (int b = 0; b < N_BANKS; b++) begin
        if (addr_i == ADDR_W'(CLR_OFS + REG_STEP * b))  rd_data_o = flag_w[b];
        if (addr_i == ADDR_W'(EN_OFS + REG_STEP * b))   rd_data_o = en_w[b];
        if (addr_i == ADDR_W'(STAT_OFS + REG_STEP * b)) rd_data_o = status_w[b];
      end
    end
  end

  irq_prio_enc #(.N(N_SRC)) u_enc (
    .req_i (status_all),
    .idx_o (pend_idx_o),
    .vld_o (pend_vld_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q      <= 1'b0;
      past_vld_q <= 1'b0;
    end else begin
      irq_q      <= |status_all;
      past_vld_q <= 1'b1;
    end
  end
  assign irq_o = irq_q;

  p_irq_delay_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld_q |-> (irq_o == $past(pend_vld_o)));

  p_vld_any_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_vld_o == (status_all != '0));

  p_idx_lowest_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_vld_o |-> (status_all[pend_idx_o] &&
                    ((status_all & ((N_SRC'(1) << pend_idx_o) - N_SRC'(1))) == '0)));

  p_idle_idx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_vld_o |-> (pend_idx_o == '0));

  p_rd_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (rd_data_o == '0));
endmodule

// File: tb/irq_bank_ctrl_test.sv
`timescale 1ns/1ps
module irq_bank_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] irq_lines_i = '0;
  logic [7:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        rd_en_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        irq_o;
  logic [5:0]  pend_idx_o;
  logic        pend_vld_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk_i = ~clk_i;

  irq_bank_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_lines_i(irq_lines_i),
    .addr_i(addr_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .irq_o(irq_o),
    .pend_idx_o(pend_idx_o), .pend_vld_o(pend_vld_o)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: pops the expected read data pushed by the driver
  always @(negedge clk_i) begin
    if (rd_en_i) begin
      if (exp_q.size() == 0) chk(32'hdead, 32'h0, "scoreboard empty");
      else chk(rd_data_o, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk_i); #1;
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(posedge clk_i); #1;
    addr_i = a; rd_en_i = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk_i); #1;
    rd_en_i = 1'b0;
  endtask

  task automatic pend(input logic v, input logic [5:0] idx, input string tag);
    @(negedge clk_i);
    chk({31'b0, pend_vld_o}, {31'b0, v}, {tag, " vld"});
    chk({26'b0, pend_idx_o}, {26'b0, idx}, {tag, " idx"});
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R7 reset state
    rd(8'h00, 32'h0, "R7 flag lo");
    rd(8'h14, 32'h0, "R7 en ext");
    rd(8'h1C, 32'h0, "R7 status ext");
    @(negedge clk_i); chk({31'b0, irq_o}, 32'h0, "R7 irq after reset");

    // one-cycle pulse on source 5
    @(posedge clk_i); #1; irq_lines_i[5] = 1'b1;
    @(posedge clk_i); #1; irq_lines_i[5] = 1'b0;
    rd(8'h00, 32'h20, "R8 flag held after pulse");
    rd(8'h18, 32'h0, "R4 status masked");
    @(negedge clk_i); chk({31'b0, irq_o}, 32'h0, "R7 masked source no irq");

    wr(8'h10, 32'h20);
    @(negedge clk_i);
    chk({31'b0, irq_o}, 32'h0, "R5 irq not yet");
    chk({31'b0, pend_vld_o}, 32'h1, "R6 vld same cycle");
    chk({26'b0, pend_idx_o}, 32'd5, "R6 idx 5");
    @(negedge clk_i); chk({31'b0, irq_o}, 32'h1, "R5 irq one cycle later");
    rd(8'h18, 32'h20, "R4 status enabled");
    rd(8'h10, 32'h20, "R3 enable readback");

    // R2 write-one-to-clear
    wr(8'h00, 32'h0);
    rd(8'h00, 32'h20, "R2 zero write keeps flag");
    wr(8'h00, 32'h20);
    @(negedge clk_i);
    chk({31'b0, pend_vld_o}, 32'h0, "R6 vld drops");
    chk({26'b0, pend_idx_o}, 32'h0, "R6 idle idx");
    rd(8'h00, 32'h0, "R2 flag cleared");
    @(negedge clk_i); chk({31'b0, irq_o}, 32'h0, "R5 irq falls");

    // extended bank, held level
    @(posedge clk_i); #1; irq_lines_i[40] = 1'b1;
    wr(8'h14, 32'h100);
    rd(8'h1C, 32'h100, "R1 source 40 in ext bit 8");
    pend(1'b1, 6'd40, "R1 ext index");
    wr(8'h04, 32'h100);
    rd(8'h04, 32'h100, "R8 set wins over clear");

    // ordering across banks
    @(posedge clk_i); #1; irq_lines_i[3] = 1'b1; irq_lines_i[7] = 1'b1;
    @(posedge clk_i); #1; irq_lines_i[3] = 1'b0; irq_lines_i[7] = 1'b0;
    wr(8'h10, 32'hFF);
    pend(1'b1, 6'd3, "R6 lowest first");
    wr(8'h00, 32'h08);
    pend(1'b1, 6'd7, "R6 next low");
    wr(8'h00, 32'h80);
    pend(1'b1, 6'd40, "R6 low bank before ext");
    @(posedge clk_i); #1; irq_lines_i[40] = 1'b0;
    wr(8'h04, 32'h100);
    pend(1'b0, 6'd0, "R2 ext cleared");

    // R9 unmapped and read-only offsets
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h08, 32'h0, "R9 unmapped reads zero");
    rd(8'h10, 32'hFF, "R9 enable untouched");
    rd(8'h00, 32'h0, "R9 flags untouched");
    rd(8'h18, 32'h0, "R9 status write ignored");
    @(posedge clk_i); #1; addr_i = 8'h10;
    @(negedge clk_i); chk(rd_data_o, 32'h0, "R9 no read strobe");
    @(negedge clk_i); chk({31'b0, irq_o}, 32'h0, "R5 idle irq");

    repeat (2) @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule